// File: doc/BRIEF.md
# Clock-Gated Pulse Counter ADC

This block is the digital back end of a rate-coded converter. A front end turns an analog level into a stream of pulses whose rate, measured against the master clock, carries the value. The block counts the rising edges of that stream over a measurement window. The window comes from a binary counter that divides down the same master clock. The count at the end of each window is therefore a ratio of pulse rate to clock rate, and drift or jitter in the clock drops out. The pulse input is asynchronous. It passes through a synchroniser and an edge detector before it reaches the counter.

Windows run back to back. The window length, in master-clock cycles, comes from a runtime input that is sampled only where one window ends and the next begins. At each boundary the finished count moves to the result bus, a one-cycle valid strobe marks it, and the counter starts again from zero. A window length that matches a whole number of interference periods rejects that interference; for example, a 100 ms window rejects both 50 Hz and 60 Hz. For N-count resolution the window must last at least N divided by the highest pulse rate. At 0.9 of a 1 MHz clock, 4096 counts need about 4.551 ms. The window does not line up with the pulses, so any result may be one count off.

Top module: `pulse_gate_adc`

## Requirements
- R1: While reset is held and right after it is released, `result_o` is 0 and `result_valid_o` is 0.
- R2: `pulse_in` passes through a synchroniser of SYNC_STAGES flops and a rising-edge detector. Each low-to-high transition counts once, however long the input then stays high, and a level that is held produces no further counts.
- R3: In the first cycle after reset release the window length is loaded and no window is open. From then on, windows of exactly L cycles follow each other with no gap, and `result_valid_o` is high for one cycle after each window ends.
- R4: On each `result_valid_o` pulse, `result_o` equals the number of input rising edges that fell in the window just ended, with a tolerance of ±1.
- R5: When a window holds more than 2^CNT_W−1 edges, the result saturates at 2^CNT_W−1 and does not wrap.
- R6: `gate_len_i` is sampled only in the last cycle of a window and on the load cycle after reset. A change in the middle of a window leaves that window's length unchanged and sets the length of the next one.
- R7: A `gate_len_i` of 0 is treated as 1, so every window lasts one cycle.
- R8: The result depends only on the ratio of window length to pulse period. Scaling both by the same factor gives the same result.
- R9: Each window starts counting from zero. A saturated or large count does not carry into the next result.
- R10: `result_o` changes only on a cycle in which `result_valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; also sets the full-scale pulse rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_in | input | 1 | Asynchronous rate-coded pulse stream |
| gate_len_i | input | LEN_W | Window length in clock cycles (0 is treated as 1) |
| result_o | output | CNT_W | Edge count of the most recent finished window |
| result_valid_o | output | 1 | One-cycle strobe that marks a new result |

## Verification
The bench builds the block with CNT_W = 6 and LEN_W = 8. With these values a 200-cycle window at the highest pulse rate of one edge every two cycles reaches the saturation ceiling of 63. Window lengths from 0 up to 200 can be switched within a short run. A behavioural model runs in step with the design and checks the strobe on every cycle and each result to within one count. Directed cases then check ratio invariance, the effect of a length change made mid-window, and clearing after saturation.

// File: rtl/pga_pkg.sv
package pga_pkg;
    typedef enum logic {
        PH_LOAD = 1'b0,
        PH_RUN  = 1'b1
    } pga_phase_e;
endpackage

// File: rtl/pga_sync_edge.sv
module pga_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    localparam int DEPTH = SYNC_STAGES + 1;

    typedef struct packed {
        logic [DEPTH-1:0] pipe;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe = {st_q.pipe[DEPTH-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.pipe[SYNC_STAGES-1] & ~st_q.pipe[SYNC_STAGES];

    // R2
    single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/pga_gate_timer.sv
module pga_gate_timer
    import pga_pkg::*;
#(
    parameter int LEN_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LEN_W-1:0] gate_len_i,
    output logic             gate_o,
    output logic             win_end_o
);
    typedef struct packed {
        pga_phase_e       phase;
        logic [LEN_W-1:0] cnt;
        logic [LEN_W-1:0] len;
    } st_t;

    st_t st_d, st_q;
    logic [LEN_W-1:0] len_ld;
    logic             last;

    always_comb begin
        len_ld = (gate_len_i == '0) ? LEN_W'(1) : gate_len_i;
        last   = (st_q.phase == PH_RUN) && (st_q.cnt == st_q.len - LEN_W'(1));
        st_d   = st_q;
        if (st_q.phase == PH_LOAD) begin
            st_d.phase = PH_RUN;
            st_d.len   = len_ld;
            st_d.cnt   = '0;
        end else if (last) begin
            st_d.len = len_ld;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + LEN_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{phase: PH_LOAD, cnt: '0, len: '0};
        else        st_q <= st_d;
    end

    assign gate_o    = (st_q.phase == PH_RUN);
    assign win_end_o = last;

    // R3
    cnt_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_RUN) |-> (st_q.cnt < st_q.len));
    // R6
    len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_RUN && !last) |=> $stable(st_q.len));
endmodule

// File: rtl/pga_sat_counter.sv
module pga_sat_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate_i,
    input  logic             inc_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] final_o
);
    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] acc;
    } st_t;

    st_t          st_d, st_q;
    logic [CNT_W:0] sum;
    logic [CNT_W-1:0] sat;

    always_comb begin
        sum  = {1'b0, st_q.acc} + {{CNT_W{1'b0}}, inc_i};
        sat  = sum[CNT_W] ? MAXV : sum[CNT_W-1:0];
        st_d = st_q;
        if (clr_i)       st_d.acc = '0;
        else if (gate_i) st_d.acc = sat;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign final_o = sat;

    // R5
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.acc == MAXV && gate_i && !clr_i) |=> (st_q.acc == MAXV));
    // R3
    closed_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_i && !clr_i) |=> $stable(st_q.acc));
    // R9
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (st_q.acc == '0));
endmodule

// File: rtl/pulse_gate_adc.sv
module pulse_gate_adc #(
    parameter int CNT_W       = 16,
    parameter int LEN_W       = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse_in,
    input  logic [LEN_W-1:0] gate_len_i,
    output logic [CNT_W-1:0] result_o,
    output logic             result_valid_o
);
    typedef struct packed {
        logic [CNT_W-1:0] res;
        logic             vld;
    } out_t;

    logic             rise, gate, win_end;
    logic [CNT_W-1:0] final_cnt;
    out_t             out_d, out_q;

    pga_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(pulse_in), .rise_o(rise)
    );

    pga_gate_timer #(.LEN_W(LEN_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .gate_len_i(gate_len_i),
        .gate_o(gate), .win_end_o(win_end)
    );

    pga_sat_counter #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .gate_i(gate), .inc_i(rise),
        .clr_i(win_end), .final_o(final_cnt)
    );

    always_comb begin
        out_d     = out_q;
        out_d.vld = win_end;
        if (win_end) out_d.res = final_cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign result_o       = out_q.res;
    assign result_valid_o = out_q.vld;

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid_o |-> $stable(result_o));
    // R3
    valid_after_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid_o |-> $past(gate));
endmodule

// File: tb/pulse_gate_adc_tb.sv
module pulse_gate_adc_tb;
    localparam int CNT_W = 6;
    localparam int LEN_W = 8;
    localparam int MAXV  = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pulse_in = 1'b0;
    logic [LEN_W-1:0] gate_len = 8'd20;
    logic [CNT_W-1:0] result;
    logic             valid;

    int checks = 0, fails = 0, cyc = 0;
    int period = 0;   // 0: low, 1: held high, >=2: square wave
    int phase = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pulse_gate_adc #(.CNT_W(CNT_W), .LEN_W(LEN_W), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .gate_len_i(gate_len),
        .result_o(result), .result_valid_o(valid)
    );

    // stimulus pattern, changed away from the active edge
    always @(negedge clk) begin
        if (period == 0)      pulse_in <= 1'b0;
        else if (period == 1) pulse_in <= 1'b1;
        else begin
            phase    = (phase + 1) % period;
            pulse_in <= (phase < period / 2);
        end
    end

    // behavioural reference model
    int m_run, m_cnt, m_len, m_acc, m_res, m_valid, h1, h2, h3;
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_run = 0; m_cnt = 0; m_len = 0; m_acc = 0; m_res = 0; m_valid = 0;
            h1 = 0; h2 = 0; h3 = 0;
        end else begin
            int e, ld, tot;
            e  = (h2 == 1 && h3 == 0) ? 1 : 0;
            h3 = h2; h2 = h1; h1 = int'(pulse_in);
            ld = (gate_len == 0) ? 1 : int'(gate_len);
            m_valid = 0;
            if (m_run == 0) begin
                m_run = 1; m_len = ld; m_cnt = 0;
            end else begin
                tot = (m_acc + e > MAXV) ? MAXV : m_acc + e;
                if (m_cnt == m_len - 1) begin
                    m_res = tot; m_valid = 1; m_acc = 0; m_cnt = 0; m_len = ld;
                end else begin
                    m_acc = tot; m_cnt++;
                end
            end
        end
    end

    // cycle-by-cycle comparison
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int d;
            checks++;
            if (int'(valid) != m_valid) begin
                fails++;
                $display("FAIL R3: valid strobe %0d expected %0d at cycle %0d", valid, m_valid, cyc);
            end
            d = int'(result) - m_res;
            checks++;
            if (d > 1 || d < -1) begin
                fails++;
                $display("FAIL R4: result %0d expected %0d (+/-1) at cycle %0d", result, m_res, cyc);
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp, input int tol);
        checks++;
        if (act > exp + tol || act < exp - tol) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_valid(output int at);
        @(negedge clk);
        while (!valid) @(negedge clk);
        at = cyc;
    endtask

    task automatic settle(input int len, input int per, output int res);
        int t;
        gate_len = LEN_W'(len);
        period = per;
        wait_valid(t); wait_valid(t); wait_valid(t);
        res = int'(result);
    endtask

    initial begin
        int r, t0, t1, t2;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk("R1 result in reset", int'(result), 0, 0);
        chk("R1 valid in reset", int'(valid), 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 result after release", int'(result), 0, 0);
        chk("R1 valid after release", int'(valid), 0, 0);

        settle(20, 0, r);   chk("R4 no pulses", r, 0, 0);
        settle(40, 4, r);   chk("R4 period 4 over 40", r, 10, 1);
        settle(80, 8, r);   chk("R8 period 8 over 80", r, 10, 1);
        settle(60, 6, r);   chk("R8 period 6 over 60", r, 10, 1);
        period = 0;
        settle(20, 1, r);   chk("R2 held level adds nothing", r, 0, 0);
        settle(200, 2, r);  chk("R5 saturation", r, MAXV, 0);
        settle(20, 2, r);   chk("R9 cleared after saturation", r, 10, 1);

        // R6 mid-window length change
        gate_len = 8'd30;
        wait_valid(t0); wait_valid(t0);
        repeat (5) @(negedge clk);
        gate_len = 8'd12;
        wait_valid(t1);
        wait_valid(t2);
        chk("R6 current window keeps old length", t1 - t0, 30, 0);
        chk("R6 next window uses new length", t2 - t1, 12, 0);
        chk("R3 window spacing", t2 - t1, 12, 0);

        // R7 zero length acts as one
        gate_len = 8'd0;
        wait_valid(t0); wait_valid(t0); wait_valid(t1);
        chk("R7 zero length gives one-cycle windows", t1 - t0, 1, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule